// File: doc/BRIEF.md
# Refresh and Realtime Clock Unit

This block keeps dynamic memory alive and keeps time from one shared periodic event. A down-counter produces a one-cycle wake pulse once per programmed period. Each wake raises a refresh request toward the memory port and advances a 32-bit realtime clock. The request carries the current row-group address. The clock gains a programmable increment in its low word, and any carry moves into its high word.

The wake period is a base count shifted left by a 2-bit select, so it is one, two, four or eight times the base. With the default base of 640 cycles and a 100 ns processor cycle, the four settings give full-array refresh cycles of 2, 4, 8 and 16 ms. The reset setting gives 2560 cycles, which is the 8 ms cycle. A short period gives more refresh margin and finer clock steps, but spends more processor cycles on refresh. A long period does the opposite. Each refresh reference covers four rows, so 32 consecutive row groups sweep a 128-row array.

The memory port acknowledges a request. Only then does the row-group address step, and only then does a busy output cover the ten cycles the port stays occupied. The software reads the clock by reading the low word and then the high word. Reading the low word freezes a copy of the high word, so a carry between the two reads cannot tear the 32-bit value.

Top module: `rfc_refresh_clock`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `clk_lo` and `clk_hi_snap` are 0, `ref_req` is 0, `ref_addr` is 0 and `mem_busy` is 0. The increment register holds 4, and the period select holds 2.
- R2: Period select values 0, 1, 2 and 3 give wake intervals of BASE_PERIOD × 1, × 2, × 4 and × 8 clock cycles. The first wake falls on the BASE_PERIOD × 4-th rising edge after reset is released.
- R3: A write to the period select (`per_wr` with `per_data`) does not shorten or stretch the interval already being counted. It sets the length of every interval loaded after the write.
- R4: On each wake, `clk_lo` becomes `clk_lo` plus the increment, modulo 2^CLK_W. A carry out of the low word adds 1 to the high word. Without a wake, `clk_lo` holds its value.
- R5: A write on `inc_wr` loads `inc_data` into the increment register. Every later wake uses that value.
- R6: A wake makes `ref_req` high in the following cycle. `ref_req` stays high until a cycle in which `ref_ack` is high, and falls after that cycle unless another wake occurs in that same cycle.
- R7: `ref_addr` is constant while a request waits. On an acknowledge, bit 9 of `ref_addr` is first cleared and then 16 is added. As a result, the row-group field `ref_addr[8:4]` counts acknowledged references modulo 32.
- R8: After an acknowledged cycle, `mem_busy` is high for exactly BUSY_CYC (default 10) cycles and then falls.
- R9: A wake that arrives while a request is still waiting does not create a second reference. `ref_req` stays high, `ref_addr` does not step, and the clock still advances.
- R10: A cycle with `rd_lo` high copies the high clock word into `clk_hi_snap`. That copy matches the `clk_lo` value shown in the same cycle. `clk_hi_snap` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_wr | input | 1 | Load strobe for the period select |
| per_data | input | 2 | New period select (0..3) |
| inc_wr | input | 1 | Load strobe for the clock increment |
| inc_data | input | CLK_W | New clock increment |
| ref_req | output | 1 | Refresh request to the memory port |
| ref_ack | input | 1 | Memory port accepts the pending refresh |
| ref_addr | output | ADDR_W | Refresh address; bits 8:4 select the row group |
| mem_busy | output | 1 | Memory port still occupied after a refresh |
| rd_lo | input | 1 | Low-word read strobe; freezes the high word |
| clk_lo | output | CLK_W | Low word of the realtime clock |
| clk_hi_snap | output | CLK_W | High word frozen at the last low-word read |

## Verification
The bench builds the unit with BASE_PERIOD set to 8. All four period settings (8 to 64 cycles) therefore occur within a few hundred cycles, and more than 32 acknowledged references occur in a few thousand cycles, so the row-group field wraps and the bit-9 clearing is exercised. BUSY_CYC keeps its default of 10, so the busy window has its real length. The bench sets the increment to 0x8000, which makes the low word carry on every second wake. The bench also holds acknowledges back over several short periods to exercise how waiting requests are merged.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    // Period multiplier selected by the 2-bit period field
    typedef enum logic [1:0] {
        PER_X1 = 2'd0,
        PER_X2 = 2'd1,
        PER_X4 = 2'd2,
        PER_X8 = 2'd3
    } period_e;

    localparam int unsigned RFC_BASE_PERIOD = 640;
    localparam int unsigned RFC_CLK_W       = 16;
    localparam int unsigned RFC_ADDR_W      = 16;
    localparam int unsigned RFC_BUSY_CYC    = 10;
    localparam int unsigned RFC_INC_RESET   = 4;
    localparam int unsigned RFC_GRP_LSB     = 4;
    localparam int unsigned RFC_GRP_BITS    = 5;

    // Events seen by the refresh sequencer in one cycle
    typedef struct packed {
        logic wake;
        logic grant;
    } ref_evt_t;

    function automatic int unsigned period_cycles(int unsigned base, period_e sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/rfc_period_timer.sv
module rfc_period_timer
    import rfc_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = RFC_BASE_PERIOD,
    parameter period_e     DEFAULT_SEL = PER_X4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       per_wr,
    input  logic [1:0] per_data,
    output logic       wake
);
    localparam int unsigned MAX_P = BASE_PERIOD << 3;
    localparam int unsigned CNT_W = $clog2(MAX_P);

    period_e          sel_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] reload_of(period_e s);
        return CNT_W'(period_cycles(BASE_PERIOD, s) - 1);
    endfunction

    assign wake = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= DEFAULT_SEL;
            cnt_q <= reload_of(DEFAULT_SEL);
        end else begin
            if (per_wr) begin
                sel_q <= period_e'(per_data);
            end
            // the select is consulted only at reload, so a write never
            // disturbs the interval in progress
            if (wake) begin
                cnt_q <= reload_of(sel_q);
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    AST_WAKE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        !wake |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3

endmodule

// File: rtl/rfc_refresh_seq.sv
module rfc_refresh_seq
    import rfc_pkg::*;
#(
    parameter int unsigned ADDR_W   = RFC_ADDR_W,
    parameter int unsigned GRP_LSB  = RFC_GRP_LSB,
    parameter int unsigned GRP_BITS = RFC_GRP_BITS,
    parameter int unsigned BUSY_CYC = RFC_BUSY_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              mem_busy
);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(1) << GRP_LSB;
    localparam logic [ADDR_W-1:0] CLR_BIT = ADDR_W'(1) << (GRP_LSB + GRP_BITS);

    ref_evt_t          evt;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;

    assign evt.wake  = wake;
    assign evt.grant = req_q & ref_ack;

    // clear the guard bit first, then step one row group
    assign addr_next = (addr_q & ~CLR_BIT) + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            // a wake while a request waits merges into it
            req_q <= evt.wake | (req_q & ~evt.grant);
            if (evt.grant) begin
                addr_q <= addr_next;
            end
        end
    end

    assign ref_req  = req_q;
    assign ref_addr = addr_q;

    generate
        if (BUSY_CYC == 0) begin : g_no_busy
            assign mem_busy = 1'b0;
        end else begin : g_busy
            localparam int unsigned BUSY_W = $clog2(BUSY_CYC + 1);
            logic [BUSY_W-1:0] busy_cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    busy_cnt <= '0;
                end else if (evt.grant) begin
                    busy_cnt <= BUSY_W'(BUSY_CYC);
                end else if (busy_cnt != '0) begin
                    busy_cnt <= busy_cnt - BUSY_W'(1);
                end
            end

            assign mem_busy = (busy_cnt != '0);

            AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
                (ref_req && ref_ack) |=> mem_busy); // R8
        end
    endgenerate

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> ref_req); // R6

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(ref_req && ref_ack) |=> $stable(ref_addr)); // R7

    AST_WAKE_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        wake |=> ref_req); // R9

endmodule

// File: rtl/rfc_rtc.sv
module rfc_rtc
    import rfc_pkg::*;
#(
    parameter int unsigned CLK_W     = RFC_CLK_W,
    parameter int unsigned INC_RESET = RFC_INC_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake,
    input  logic             inc_wr,
    input  logic [CLK_W-1:0] inc_data,
    input  logic             rd_lo,
    output logic [CLK_W-1:0] clk_lo,
    output logic [CLK_W-1:0] clk_hi_snap
);
    logic [CLK_W-1:0] lo_q;
    logic [CLK_W-1:0] hi_q;
    logic [CLK_W-1:0] inc_q;
    logic [CLK_W-1:0] snap_q;
    logic [CLK_W:0]   sum;

    assign sum = {1'b0, lo_q} + {1'b0, inc_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            inc_q  <= CLK_W'(INC_RESET);
            snap_q <= '0;
        end else begin
            if (inc_wr) begin
                inc_q <= inc_data;
            end
            if (wake) begin
                lo_q <= sum[CLK_W-1:0];
                hi_q <= hi_q + CLK_W'(sum[CLK_W]);
            end
            // freeze the pre-edge high word that pairs with the low word
            // presented in this cycle
            if (rd_lo) begin
                snap_q <= hi_q;
            end
        end
    end

    assign clk_lo      = lo_q;
    assign clk_hi_snap = snap_q;

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wake |=> $stable(clk_lo)); // R4

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (clk_hi_snap == $past(hi_q))); // R10

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_lo |=> $stable(clk_hi_snap)); // R10

    AST_HI_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        !wake |=> $stable(hi_q)); // R4

endmodule

// File: rtl/rfc_refresh_clock.sv
module rfc_refresh_clock
    import rfc_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = RFC_BASE_PERIOD,
    parameter int unsigned CLK_W       = RFC_CLK_W,
    parameter int unsigned ADDR_W      = RFC_ADDR_W,
    parameter int unsigned BUSY_CYC    = RFC_BUSY_CYC,
    parameter int unsigned INC_RESET   = RFC_INC_RESET,
    parameter int unsigned GRP_LSB     = RFC_GRP_LSB,
    parameter int unsigned GRP_BITS    = RFC_GRP_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              per_wr,
    input  logic [1:0]        per_data,
    input  logic              inc_wr,
    input  logic [CLK_W-1:0]  inc_data,
    output logic              ref_req,
    input  logic              ref_ack,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              mem_busy,
    input  logic              rd_lo,
    output logic [CLK_W-1:0]  clk_lo,
    output logic [CLK_W-1:0]  clk_hi_snap
);
    logic wake;

    rfc_period_timer #(
        .BASE_PERIOD (BASE_PERIOD),
        .DEFAULT_SEL (PER_X4)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .per_wr   (per_wr),
        .per_data (per_data),
        .wake     (wake)
    );

    rfc_refresh_seq #(
        .ADDR_W   (ADDR_W),
        .GRP_LSB  (GRP_LSB),
        .GRP_BITS (GRP_BITS),
        .BUSY_CYC (BUSY_CYC)
    ) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .wake     (wake),
        .ref_ack  (ref_ack),
        .ref_req  (ref_req),
        .ref_addr (ref_addr),
        .mem_busy (mem_busy)
    );

    rfc_rtc #(
        .CLK_W     (CLK_W),
        .INC_RESET (INC_RESET)
    ) u_rtc (
        .clk         (clk),
        .rst         (rst),
        .wake        (wake),
        .inc_wr      (inc_wr),
        .inc_data    (inc_data),
        .rd_lo       (rd_lo),
        .clk_lo      (clk_lo),
        .clk_hi_snap (clk_hi_snap)
    );

endmodule

// File: tb/rfc_refresh_clock_bench.sv
`timescale 1ns/1ps
module rfc_refresh_clock_bench;
    localparam int BASE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        per_wr = 1'b0;
    logic [1:0]  per_data = 2'd0;
    logic        inc_wr = 1'b0;
    logic [15:0] inc_data = 16'd0;
    logic        ref_req;
    logic        ref_ack = 1'b0;
    logic [15:0] ref_addr;
    logic        mem_busy;
    logic        rd_lo = 1'b0;
    logic [15:0] clk_lo;
    logic [15:0] clk_hi_snap;

    always #2.5 clk = ~clk;

    rfc_refresh_clock #(.BASE_PERIOD(BASE)) u_rfc_refresh_clock (
        .clk(clk), .rst(rst), .per_wr(per_wr), .per_data(per_data),
        .inc_wr(inc_wr), .inc_data(inc_data), .ref_req(ref_req),
        .ref_ack(ref_ack), .ref_addr(ref_addr), .mem_busy(mem_busy),
        .rd_lo(rd_lo), .clk_lo(clk_lo), .clk_hi_snap(clk_hi_snap)
    );

    typedef struct {
        logic [15:0] lo;
        int          gap;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    int          last_cyc = 0;
    int          pop_cnt = 0;
    int          ack_cnt = 0;
    int          ack_dly = 0;
    bit          ack_en = 1'b1;
    logic [15:0] last_lo = 16'd0;
    logic [15:0] m_lo = 16'd0;
    logic [15:0] m_hi = 16'd0;
    logic [15:0] m_inc = 16'd4;
    logic [15:0] exp_addr = 16'd0;
    logic [15:0] held_addr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // driver: model one wake and queue the expected result
    task automatic push_wake(input int gap, input string tag);
        exp_t e;
        logic [16:0] s;
        s = {1'b0, m_lo} + {1'b0, m_inc};
        m_lo = s[15:0];
        m_hi = m_hi + {15'd0, s[16]};
        e.lo = m_lo; e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: pop and compare on every clock-word change
    always @(negedge clk) begin
        if (!rst && clk_lo != last_lo) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected wake", clk_lo, last_lo);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(clk_lo == e.lo, {e.tag, " R4 low word"}, clk_lo, e.lo);
                chk((cyc - last_cyc) == e.gap, {e.tag, " interval"}, cyc - last_cyc, e.gap);
                chk(ref_req == 1'b1, "R6 request after wake", ref_req, 1);
            end
            last_lo  = clk_lo;
            last_cyc = cyc;
            pop_cnt++;
        end
    end

    // memory-port responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ack_en && ref_req) begin
                held_addr = ref_addr;
                for (int d = 0; d < ack_dly; d++) begin
                    @(negedge clk);
                    chk(ref_req == 1'b1, "R6 request held", ref_req, 1);
                    chk(ref_addr == held_addr, "R7 address stable", ref_addr, held_addr);
                end
                chk(ref_addr == exp_addr, "R7 address at ack", ref_addr, exp_addr);
                ref_ack = 1'b1;
                @(negedge clk);
                ref_ack = 1'b0;
                exp_addr = (exp_addr & ~16'h0200) + 16'h0010;
                ack_cnt++;
                chk(ref_req == 1'b0, "R6 request drops", ref_req, 0);
                chk(ref_addr == exp_addr, "R7 address step", ref_addr, exp_addr);
                chk(ref_addr[8:4] == 5'(ack_cnt % 32), "R7 row group", ref_addr[8:4], ack_cnt % 32);
                chk(mem_busy == 1'b1, "R8 busy start", mem_busy, 1);
                repeat (9) begin
                    @(negedge clk);
                    chk(mem_busy == 1'b1, "R8 busy window", mem_busy, 1);
                end
                @(negedge clk);
                chk(mem_busy == 1'b0, "R8 busy end", mem_busy, 0);
                ack_dly = (ack_dly == 0) ? 3 : 0;
            end
        end
    end

    task automatic write_per(input logic [1:0] v);
        @(negedge clk); per_wr = 1'b1; per_data = v;
        @(negedge clk); per_wr = 1'b0;
    endtask

    task automatic read_clock(input string tag);
        @(negedge clk); rd_lo = 1'b1;
        chk(clk_lo == m_lo, {tag, " R10 low read"}, clk_lo, m_lo);
        @(negedge clk); rd_lo = 1'b0;
        chk(clk_hi_snap == m_hi, {tag, " R10 high snapshot"}, clk_hi_snap, m_hi);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(clk_lo == 16'd0, "R1 low word", clk_lo, 0);
        chk(clk_hi_snap == 16'd0, "R1 snapshot", clk_hi_snap, 0);
        chk(ref_req == 1'b0, "R1 request", ref_req, 0);
        chk(ref_addr == 16'd0, "R1 address", ref_addr, 0);
        chk(mem_busy == 1'b0, "R1 busy", mem_busy, 0);

        // R2 default select 2, increment 4 from reset (R1)
        repeat (3) push_wake(BASE * 4, "R2 default");
        wait (pop_cnt == 3);

        // R3 new select applies after the current interval
        write_per(2'd1);
        push_wake(BASE * 4, "R3 old interval");
        push_wake(BASE * 2, "R3 new interval");
        push_wake(BASE * 2, "R2 select 1");
        wait (pop_cnt == 6);

        // R5 increment change; R4 carry into high word
        @(negedge clk); inc_wr = 1'b1; inc_data = 16'h8000;
        @(negedge clk); inc_wr = 1'b0;
        m_inc = 16'h8000;
        push_wake(BASE * 2, "R5 new increment");
        push_wake(BASE * 2, "R4 carry");
        wait (pop_cnt == 8);
        read_clock("R4");

        // R9 merged wakes while acknowledges are held back
        ack_en = 1'b0;
        write_per(2'd0);
        push_wake(BASE * 2, "R3 select 1 finishing");
        push_wake(BASE, "R2 select 0");
        push_wake(BASE, "R9 merge");
        push_wake(BASE, "R9 merge");
        push_wake(BASE * 8, "R2 select 3");
        wait (pop_cnt == 11);
        write_per(2'd3);
        wait (pop_cnt == 12);
        chk(ref_req == 1'b1, "R9 request pending", ref_req, 1);
        chk(ref_addr == exp_addr, "R9 address not stepped", ref_addr, exp_addr);
        ack_en = 1'b1;
        wait (pop_cnt == 13);

        // R7 row-group wrap over more than 32 references
        for (int i = 0; i < 34; i++) push_wake(BASE * 8, "R7 sweep");
        wait (pop_cnt == 47);
        chk(ack_cnt >= 33, "R7 references past wrap", ack_cnt, 33);
        read_clock("R10");

        repeat (20) @(negedge clk);
        summary();
        $finish;
    end
endmodule